// File: doc/BRIEF.md
# Elastic Skip FIFO

This block carries a stream of received symbols from the recovered receive clock to the local system clock. The system clock is usually the transmit clock. Each symbol is an 8-bit value with a control (K) flag. Storage is a 16-entry dual-clock FIFO. Each side converts its pointer to Gray code, and the other side samples that pointer through a two-flop synchronizer. Each side works out its own view of the fill level from its own pointer and the synchronized one.

In rate-matching mode the block absorbs a small frequency offset between the two clocks. It does this by removing or repeating a configured skip symbol so that the fill stays near half depth:
- On the write side, a skip that arrives while the fill is high is not stored.
- On the read side, a skip that has just come out is emitted a second time while the fill is low.

Every symbol delivered downstream carries a 2-bit status:
- `00`: plain symbol.
- `01`: skip added by the block.
- `10`: a skip was removed just before this symbol.
- `11`: an overflow or underflow occurred.

When `cfg_phase_only` is set, the block is a plain phase-compensation FIFO. It passes every stored symbol exactly once, and the two clocks are assumed to run at the same frequency.

The downstream logic pulls symbols with `rd_en`. It then sees the result one read clock later on `rd_valid`, `rd_data`, `rd_is_k` and `rd_status`.

Top module: `elastic_skip_fifo`

## Requirements
- R1: While either reset is asserted, and after reset with no read request, `rd_valid` is 0 and `rd_status` is 00.
- R2: With `cfg_phase_only`=1, every accepted symbol, skips included, comes out exactly once, in write order, with status 00. This holds whatever the fill level.
- R3: With `cfg_phase_only`=0, every symbol that is not a removable skip comes out once, in write order, with its data and K flag unchanged. A request on cycle t gives `rd_valid`=1 on cycle t+1.
- R4: With `cfg_phase_only`=0, a symbol is not stored when all of these hold:
  - `wr_is_k`=1;
  - `wr_data` equals `cfg_skip`;
  - the write-side fill is greater than 10 (half depth plus 2).
  The next stored symbol then comes out with status 10.
- R5: A skip is stored normally in either of these cases:
  - the write-side fill is 10 or less;
  - the byte equals `cfg_skip` but `wr_is_k`=0.
- R6: With `cfg_phase_only`=0, an extra skip is emitted without popping the FIFO when all of these hold:
  - `rd_en`=1;
  - the read-side fill is below 6;
  - the previous output was a skip K symbol taken from storage.
  The extra skip has `rd_data`=`cfg_skip`, `rd_is_k`=1 and status 01. An added skip never triggers another addition.
- R7: A read request when the FIFO is empty, with no addition due, gives `rd_valid`=0 and `rd_status`=11 on the next cycle.
- R8: A write while 16 symbols are held is dropped. The next symbol that is stored comes out with status 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_valid | input | 1 | A symbol is present on `wr_data` this cycle |
| wr_data | input | 8 | Received symbol value |
| wr_is_k | input | 1 | Received symbol is a control (K) symbol |
| rd_clk | input | 1 | System clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read side |
| rd_en | input | 1 | Request one output symbol |
| rd_valid | output | 1 | A symbol is present on the outputs this cycle |
| rd_data | output | 8 | Output symbol value |
| rd_is_k | output | 1 | Output symbol is a control (K) symbol |
| rd_status | output | 2 | 00 normal, 01 skip added, 10 skip removed, 11 overflow or underflow |
| cfg_skip | input | 8 | Skip symbol value, static during operation |
| cfg_phase_only | input | 1 | 1 selects plain phase compensation, static during operation |

## Verification
The assertions check the following on every cycle:
- both Gray pointers change by at most one bit per clock;
- the write-side fill never exceeds the depth;
- an added-skip status only ever appears on a valid skip K symbol, and never in phase-compensation mode;
- a non-valid output never carries the added or removed codes;
- in phase-compensation mode, every write that finds room advances the write pointer.

Several behaviours depend on the fill level the stream has built up, so only the bench scenarios can show them:
- the exact point at which a skip is kept or removed;
- the single repeat after a stored skip;
- the status-11 marking after a dropped write;
- the in-order stream under concurrent writes and reads.

// File: rtl/elastic_skip_fifo.sv
module elastic_skip_fifo #(
  parameter int W      = 8,
  parameter int AW     = 4,
  parameter int MARGIN = 2
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  input  logic         wr_is_k,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_en,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_is_k,
  output logic [1:0]   rd_status,
  input  logic [W-1:0] cfg_skip,
  input  logic         cfg_phase_only
);
  localparam int DEPTH = 1 << AW;
  localparam int EW    = W + 3;
  localparam logic [AW:0] FULL_L = (AW+1)'(DEPTH);
  localparam logic [AW:0] HI_L   = (AW+1)'(DEPTH / 2 + MARGIN);
  localparam logic [AW:0] LO_L   = (AW+1)'(DEPTH / 2 - MARGIN);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [EW-1:0] mem [DEPTH];

  // write side
  logic [AW:0] wr_bin, wr_gray, rq1, rq2, wr_fill, wr_bin_nx;
  logic        pend_del, pend_err, wr_full, wr_drop_skip, wr_push, wr_ovf;
  logic [1:0]  wr_mark;

  assign wr_fill      = wr_bin - g2b(rq2);
  assign wr_full      = (wr_fill == FULL_L);
  assign wr_drop_skip = wr_valid && !cfg_phase_only && wr_is_k &&
                        (wr_data == cfg_skip) && (wr_fill > HI_L);
  assign wr_push      = wr_valid && !wr_drop_skip && !wr_full;
  assign wr_ovf       = wr_valid && !wr_drop_skip && wr_full;
  assign wr_mark      = pend_err ? 2'b11 : (pend_del ? 2'b10 : 2'b00);
  assign wr_bin_nx    = wr_bin + 1'b1;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wr_bin   <= '0;
      wr_gray  <= '0;
      rq1      <= '0;
      rq2      <= '0;
      pend_del <= 1'b0;
      pend_err <= 1'b0;
    end else begin
      rq1 <= rd_gray;
      rq2 <= rq1;
      if (wr_push) begin
        wr_bin   <= wr_bin_nx;
        wr_gray  <= wr_bin_nx ^ (wr_bin_nx >> 1);
        pend_del <= 1'b0;
        pend_err <= 1'b0;
      end else begin
        if (wr_drop_skip) pend_del <= 1'b1;
        if (wr_ovf)       pend_err <= 1'b1;
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_push) mem[wr_bin[AW-1:0]] <= {wr_mark, wr_is_k, wr_data};

  // read side
  logic [AW:0]   rd_bin, rd_gray, wq1, wq2, rd_fill, rd_bin_nx;
  logic [EW-1:0] head;
  logic          last_skip, rd_empty, do_ins, do_pop, do_uflow, head_skip;

  assign head      = mem[rd_bin[AW-1:0]];
  assign rd_fill   = g2b(wq2) - rd_bin;
  assign rd_empty  = (rd_fill == '0);
  assign do_ins    = rd_en && !cfg_phase_only && last_skip && (rd_fill < LO_L);
  assign do_pop    = rd_en && !do_ins && !rd_empty;
  assign do_uflow  = rd_en && !do_ins && rd_empty;
  assign head_skip = head[W] && (head[W-1:0] == cfg_skip);
  assign rd_bin_nx = rd_bin + 1'b1;

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rd_bin    <= '0;
      rd_gray   <= '0;
      wq1       <= '0;
      wq2       <= '0;
      last_skip <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      rd_is_k   <= 1'b0;
      rd_status <= 2'b00;
    end else begin
      wq1       <= wr_gray;
      wq2       <= wq1;
      rd_valid  <= do_ins || do_pop;
      rd_data   <= do_ins ? cfg_skip : head[W-1:0];
      rd_is_k   <= do_ins || (do_pop && head[W]);
      rd_status <= do_ins ? 2'b01 : do_pop ? head[W+2:W+1] : do_uflow ? 2'b11 : 2'b00;
      if (rd_en) last_skip <= do_pop && head_skip;
      if (do_pop) begin
        rd_bin  <= rd_bin_nx;
        rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
      end
    end

  // checks
  assert_wr_gray_step_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);
  assert_rd_gray_step_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);
  assert_no_overflow_R8: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_fill <= FULL_L);
  assert_added_is_skip_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_status == 2'b01 |-> rd_valid && rd_is_k && rd_data == cfg_skip);
  assert_phase_no_add_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    cfg_phase_only |=> rd_status != 2'b01);
  assert_phase_keeps_all_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    cfg_phase_only && wr_valid && !wr_full |=> wr_bin == $past(wr_bin) + 1'b1);
  assert_idle_status_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_valid |-> rd_status != 2'b01 && rd_status != 2'b10);
endmodule

// File: tb/elastic_skip_fifo_bench.sv
`timescale 1ns/1ps
module elastic_skip_fifo_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, wr_valid, wr_is_k, rd_en, phase_only;
  logic [7:0] wr_data, skip;
  logic       rd_valid, rd_is_k;
  logic [7:0] rd_data;
  logic [1:0] rd_status;

  elastic_skip_fifo u_elastic_skip_fifo (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_is_k(wr_is_k),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_is_k(rd_is_k), .rd_status(rd_status), .cfg_skip(skip), .cfg_phase_only(phase_only));

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] q_d[$];
  logic       q_k[$];
  logic [1:0] q_s[$];
  string      q_t[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expect_sym(input logic [7:0] d, input logic k, input logic [1:0] s, input string tag);
    q_d.push_back(d); q_k.push_back(k); q_s.push_back(s); q_t.push_back(tag);
  endtask

  always @(negedge clk) begin
    logic [7:0] ed; logic ek; logic [1:0] es; string et;
    if (rst_n && rd_valid) begin
      if (q_d.size() == 0)
        check(1'b0, "R3", "unexpected output", {21'd0, rd_status, rd_is_k, rd_data}, 0);
      else begin
        ed = q_d.pop_front(); ek = q_k.pop_front(); es = q_s.pop_front(); et = q_t.pop_front();
        check(rd_data == ed && rd_is_k == ek && rd_status == es, et, "symbol {status,k,data}",
              {21'd0, rd_status, rd_is_k, rd_data}, {21'd0, es, ek, ed});
      end
    end
  end

  task automatic put(input logic [7:0] d, input logic k);
    @(negedge clk); wr_valid = 1'b1; wr_data = d; wr_is_k = k;
  endtask
  task automatic wr_idle; @(negedge clk); wr_valid = 1'b0; endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rd_en = 1'b1; end
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic underflow_check;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(!rd_valid && rd_status == 2'b11, "R7", "underflow {valid,status}",
          {29'd0, rd_valid, rd_status}, 32'h3);
    @(negedge clk);
    check(!rd_valid && rd_status == 2'b00, "R1", "idle {valid,status}",
          {29'd0, rd_valid, rd_status}, 32'h0);
  endtask
  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_is_k = 1'b0; wr_data = '0; rd_en = 1'b0;
    skip = 8'h1C; phase_only = 1'b1;
    idle(4);
    check(!rd_valid && rd_status == 2'b00, "R1", "in reset {valid,status}",
          {29'd0, rd_valid, rd_status}, 32'h0);
    rst_n = 1'b1;
    idle(4);
    check(!rd_valid && rd_status == 2'b00, "R1", "after reset {valid,status}",
          {29'd0, rd_valid, rd_status}, 32'h0);

    // phase mode: fill to full, drop one, skips kept at any fill (R2, R8)
    for (int i = 0; i < 17; i++) begin
      logic [7:0] d; logic k;
      k = (i == 12 || i == 14);
      d = k ? skip : 8'h40 + 8'(i);
      put(d, k);
      if (i < 16) expect_sym(d, k, 2'b00, "R2");
    end
    wr_idle();
    idle(6); reads(1); idle(6);
    put(8'h7E, 1'b0); expect_sym(8'h7E, 1'b0, 2'b11, "R8");
    wr_idle();
    idle(6); reads(16); idle(4);
    check(q_d.size() == 0, "R2", "pending expected items", q_d.size(), 0);
    underflow_check();

    // rate matching: keep, remove, repeat (R4, R5, R6)
    phase_only = 1'b0;
    idle(2);
    for (int i = 0; i < 10; i++) begin
      put(8'h20 + 8'(i), 1'b0); expect_sym(8'h20 + 8'(i), 1'b0, 2'b00, "R3");
    end
    put(skip, 1'b1); expect_sym(skip, 1'b1, 2'b00, "R5");
    expect_sym(skip, 1'b1, 2'b01, "R6");
    put(skip, 1'b1);
    put(8'h55, 1'b0); expect_sym(8'h55, 1'b0, 2'b10, "R4");
    put(skip, 1'b0); expect_sym(skip, 1'b0, 2'b00, "R5");
    wr_idle();
    idle(6); reads(14); idle(4);
    check(q_d.size() == 0, "R6", "pending expected items", q_d.size(), 0);
    underflow_check();

    // streaming with concurrent write and read (R3)
    for (int i = 0; i < 8; i++) begin
      put(8'h80 + 8'(i), (i % 3) == 0); expect_sym(8'h80 + 8'(i), (i % 3) == 0, 2'b00, "R3");
    end
    wr_idle();
    idle(6);
    fork
      begin
        for (int i = 8; i < 48; i++) begin
          put(8'h80 + 8'(i), (i % 3) == 0); expect_sym(8'h80 + 8'(i), (i % 3) == 0, 2'b00, "R3");
        end
        wr_idle();
      end
      reads(40);
    join
    idle(6); reads(8); idle(4);
    check(q_d.size() == 0, "R3", "pending expected items", q_d.size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule